// File: doc/BRIEF.md
# Immediate-Operand Instruction Executor

This block runs a small family of 32-bit instructions that each end in a four-byte immediate. Bytes arrive one at a time on a valid/ready stream. The block decodes the opcode and, when the form calls for it, one addressing byte. It then gathers the immediate and executes the instruction in a single cycle. The instruction may update an eight-entry register file, a word-addressed data memory, and the sign, zero and overflow flags.

Four instruction shapes are supported: accumulator short forms that work on register 0, a group opcode whose addressing byte picks both the operation and the destination, a move-immediate family, and a push-immediate. A destination is either a register or the memory word addressed by a register. Any encoding outside this set halts the executor. The halt holds until reset and shows on an error output. A debug port reads any register and any memory word without side effects, so results can be observed from outside.

Top module: `imm_exec_core`

## Requirements
- R1: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low in the execute cycle that follows the last immediate byte, and it stays low while the block is halted.
- R2: The four immediate bytes arrive least significant first, so the stream 0a 0b 0c 0d forms 0x0d0c0b0a.
- R3: Opcode 0x81 is followed by an addressing byte and then the immediate. Bits 5:3 of the addressing byte choose the operation: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. When bits 7:6 equal 3, the destination is the register numbered by bits 2:0.
- R4: When bits 7:6 of the addressing byte equal 0, the destination is a memory word. Its word index is taken from bits [MAW+1:2] of the register named by bits 2:0 (a byte address divided by four).
- R5: Each accumulator short form has no addressing byte and acts on register 0: 0x2d subtracts, 0x25 ands, 0x0d ors, 0x35 xors and 0x3d compares.
- R6: Opcodes 0xb8 to 0xbf write the immediate into the register given by the low three opcode bits.
- R7: Opcode 0xc7 takes an addressing byte whose bits 5:3 must be 0. It writes the immediate to the register or memory destination that the byte selects.
- R8: Opcode 0x68 lowers register 4 by 4. It then stores the immediate in the memory word addressed by the new register 4 value.
- R9: Add, subtract and compare set the sign flag to bit 31 of the result, set the zero flag when the result is zero, and set the overflow flag on signed overflow. And, or and xor set sign and zero the same way and clear overflow. Move, store and push leave all three flags unchanged.
- R10: Compare updates only the flags. It writes no register and no memory word.
- R11: Any of the following halts the block: an opcode outside the set, operation code 2 or 3 under 0x81, a nonzero bits 5:3 under 0xc7, addressing-byte bits 7:6 equal to 1 or 2, or bits 7:6 equal to 0 with bits 2:0 equal to 4 or 5. From the cycle after the offending byte, `err` is high and `in_ready` is low until reset.
- R12: `done` is high for exactly one cycle, the cycle after the write-back edge. The new state is visible on the debug port in that cycle.
- R13: After reset all registers, memory words and flags read 0, `err` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte is present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block will take a byte on this edge |
| done | output | 1 | One-cycle pulse after an instruction's write-back |
| err | output | 1 | Sticky halt on an unsupported encoding |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Signed overflow flag |
| dbg_reg_sel | input | 3 | Register number to read |
| dbg_reg_val | output | 32 | Contents of the selected register |
| dbg_mem_sel | input | 5 | Memory word index to read (MAW bits) |
| dbg_mem_val | output | 32 | Contents of the selected memory word |

## Verification
The assertions check on every cycle that the halt is sticky and keeps `in_ready` low, and that execution comes only after four immediate bytes. They also check that `done` never lasts two cycles, that the flags stay fixed unless an arithmetic or logic operation runs, and that a memory write reads back on the next cycle. Other behaviour shows only in the bench's scenarios. These include the numeric results of each operation and the signed-overflow cases at the 0x7fffffff/0x80000000 boundary. They also include the byte order of the immediate, the order of the stack-pointer decrement and the store, and the full list of illegal encodings.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

  localparam int XLEN = 32;
  localparam int NREG = 8;
  localparam logic [2:0] SP_IDX = 3'd4;

  // Operation codes follow the group-opcode field; 2 is free and used for "pass immediate"
  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_OR   = 3'd1,
    ALU_PASS = 3'd2,
    ALU_AND  = 3'd4,
    ALU_SUB  = 3'd5,
    ALU_XOR  = 3'd6,
    ALU_CMP  = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_IMM, ST_EXEC, ST_HALT
  } dec_state_e;

  typedef struct packed {
    logic            push;
    alu_op_e         op;
    logic            dst_mem;
    logic [2:0]      rnum;
    logic [XLEN-1:0] imm;
  } exec_req_t;

  typedef struct packed {
    logic       ok;
    logic       want_modrm;
    logic       grp;
    logic       push;
    alu_op_e    op;
    logic [2:0] rnum;
  } opc_info_t;

  typedef struct packed {
    logic [XLEN-1:0] res;
    logic            sf;
    logic            zf;
    logic            of;
    logic            upd;
    logic            wb;
  } alu_out_t;

  function automatic opc_info_t classify_opcode(logic [7:0] b);
    opc_info_t d;
    d      = '0;
    d.ok   = 1'b1;
    d.op   = ALU_PASS;
    if (b[7:3] == 5'b10111) begin
      d.rnum = b[2:0];
    end else begin
      case (b)
        8'h81: begin d.want_modrm = 1'b1; d.grp = 1'b1; end
        8'hc7: d.want_modrm = 1'b1;
        8'h2d: d.op = ALU_SUB;
        8'h25: d.op = ALU_AND;
        8'h0d: d.op = ALU_OR;
        8'h35: d.op = ALU_XOR;
        8'h3d: d.op = ALU_CMP;
        8'h68: d.push = 1'b1;
        default: d.ok = 1'b0;
      endcase
    end
    return d;
  endfunction

  function automatic logic modrm_ok(logic grp, logic [7:0] m);
    logic bad_mode, bad_base, bad_sub;
    bad_mode = (m[7:6] == 2'b01) || (m[7:6] == 2'b10);
    bad_base = (m[7:6] == 2'b00) && ((m[2:0] == 3'd4) || (m[2:0] == 3'd5));
    bad_sub  = grp ? ((m[5:3] == 3'd2) || (m[5:3] == 3'd3)) : (m[5:3] != 3'd0);
    return !(bad_mode || bad_base || bad_sub);
  endfunction

  function automatic alu_out_t alu_eval(alu_op_e op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    alu_out_t o;
    logic [XLEN-1:0] r;
    logic v;
    logic upd;
    v   = 1'b0;
    upd = 1'b1;
    case (op)
      ALU_ADD: begin
        r = a + b;
        v = (a[XLEN-1] == b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
      end
      ALU_SUB, ALU_CMP: begin
        r = a - b;
        v = (a[XLEN-1] != b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
      end
      ALU_OR:  r = a | b;
      ALU_AND: r = a & b;
      ALU_XOR: r = a ^ b;
      default: begin r = b; upd = 1'b0; end
    endcase
    o.res = r;
    o.sf  = r[XLEN-1];
    o.zf  = (r == '0);
    o.of  = v;
    o.upd = upd;
    o.wb  = (op != ALU_CMP);
    return o;
  endfunction

endpackage

// File: rtl/imm_exec_decode.sv
module imm_exec_decode
  import imm_exec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  logic [7:0] in_byte,
  output logic      in_ready,
  output logic      exec_go,
  output logic      halted,
  output exec_req_t req
);

  dec_state_e state;
  logic [1:0] cnt;
  logic       grp_q;
  exec_req_t  req_q;
  opc_info_t  info;
  logic       take;

  assign in_ready = (state == ST_OPC) || (state == ST_MODRM) || (state == ST_IMM);
  assign take     = in_valid && in_ready;
  assign exec_go  = (state == ST_EXEC);
  assign halted   = (state == ST_HALT);
  assign req      = req_q;

  always_comb info = classify_opcode(in_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPC;
      cnt   <= '0;
      grp_q <= 1'b0;
      req_q <= '0;
    end else begin
      case (state)
        ST_OPC: if (take) begin
          if (!info.ok) begin
            state <= ST_HALT;
          end else begin
            req_q.push    <= info.push;
            req_q.op      <= info.op;
            req_q.dst_mem <= 1'b0;
            req_q.rnum    <= info.rnum;
            grp_q         <= info.grp;
            cnt           <= '0;
            state         <= info.want_modrm ? ST_MODRM : ST_IMM;
          end
        end
        ST_MODRM: if (take) begin
          if (!modrm_ok(grp_q, in_byte)) begin
            state <= ST_HALT;
          end else begin
            req_q.dst_mem <= (in_byte[7:6] == 2'b00);
            req_q.rnum    <= in_byte[2:0];
            if (grp_q) req_q.op <= alu_op_e'(in_byte[5:3]);
            state <= ST_IMM;
          end
        end
        ST_IMM: if (take) begin
          req_q.imm <= {in_byte, req_q.imm[XLEN-1:8]};
          cnt       <= cnt + 2'd1;
          if (cnt == 2'd3) state <= ST_EXEC;
        end
        ST_EXEC: state <= ST_OPC;
        default: state <= ST_HALT;
      endcase
    end
  end

  // R11: once halted, the decoder never leaves the halt state
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state == ST_HALT));

  // R2: execution follows directly on the fourth immediate byte
  p_exec_after_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> ($past(state) == ST_IMM) && ($past(cnt) == 2'd3));

  // R12: execute lasts a single cycle
  p_exec_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !exec_go);

endmodule

// File: rtl/imm_exec_regfile.sv
module imm_exec_regfile
  import imm_exec_pkg::*;
#(
  parameter int NR = NREG,
  parameter int W  = XLEN,
  localparam int IW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wd,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rd,
  input  logic [IW-1:0] dbg_idx,
  output logic [W-1:0]  dbg_rd
);

  logic [W-1:0] regs [NR];

  for (genvar i = 0; i < NR; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= '0;
      else if (we && (widx == IW'(i)))   q <= wd;
    end
    assign regs[i] = q;
  end

  assign rd     = regs[ridx];
  assign dbg_rd = regs[dbg_idx];

endmodule

// File: rtl/imm_exec_dmem.sv
module imm_exec_dmem
  import imm_exec_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int W     = XLEN,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_rd
);

  logic [W-1:0] words [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) words[k] <= '0;
    end else if (we) begin
      words[addr] <= wd;
    end
  end

  assign rd     = words[addr];
  assign dbg_rd = words[dbg_addr];

  // R4: a written word holds the written value on the next cycle
  p_store_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (words[$past(addr)] == $past(wd)));

endmodule

// File: rtl/imm_exec_core.sv
module imm_exec_core
  import imm_exec_pkg::*;
#(
  parameter int MEM_WORDS = 32,
  localparam int MAW = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            in_ready,
  output logic            done,
  output logic            err,
  output logic            flag_sign,
  output logic            flag_zero,
  output logic            flag_ovf,
  input  logic [2:0]      dbg_reg_sel,
  output logic [XLEN-1:0] dbg_reg_val,
  input  logic [MAW-1:0]  dbg_mem_sel,
  output logic [XLEN-1:0] dbg_mem_val
);

  exec_req_t       req;
  logic            exec_go;
  logic            halted;
  logic [2:0]      rd_idx;
  logic [XLEN-1:0] rd_val;
  logic [XLEN-1:0] sp_next;
  logic [XLEN-1:0] eff_addr;
  logic [MAW-1:0]  mem_idx;
  logic [XLEN-1:0] mem_rd;
  logic [XLEN-1:0] opa;
  alu_out_t        alu;
  logic            reg_we, mem_we;
  logic [XLEN-1:0] reg_wd, mem_wd;
  logic            flag_evt;
  logic            done_q;
  logic            unused_addr_bits;

  imm_exec_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_ready (in_ready),
    .exec_go  (exec_go),
    .halted   (halted),
    .req      (req)
  );

  // Operand fetch: stack pointer for push, otherwise the named register
  assign rd_idx   = req.push ? SP_IDX : req.rnum;
  assign sp_next  = rd_val - XLEN'(4);
  assign eff_addr = req.push ? sp_next : rd_val;
  assign mem_idx  = eff_addr[MAW+1:2];
  assign unused_addr_bits = ^{eff_addr[XLEN-1:MAW+2], eff_addr[1:0]};
  assign opa      = req.dst_mem ? mem_rd : rd_val;

  always_comb alu = alu_eval(req.op, opa, req.imm);

  assign reg_we = exec_go && (req.push || (!req.dst_mem && alu.wb));
  assign reg_wd = req.push ? sp_next : alu.res;
  assign mem_we = exec_go && (req.push || (req.dst_mem && alu.wb));
  assign mem_wd = req.push ? req.imm : alu.res;
  assign flag_evt = exec_go && !req.push && alu.upd;

  imm_exec_regfile #(.NR(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .widx    (rd_idx),
    .wd      (reg_wd),
    .ridx    (rd_idx),
    .rd      (rd_val),
    .dbg_idx (dbg_reg_sel),
    .dbg_rd  (dbg_reg_val)
  );

  imm_exec_dmem #(.WORDS(MEM_WORDS), .W(XLEN)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mem_we),
    .addr     (mem_idx),
    .wd       (mem_wd),
    .rd       (mem_rd),
    .dbg_addr (dbg_mem_sel),
    .dbg_rd   (dbg_mem_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_sign <= 1'b0;
      flag_zero <= 1'b0;
      flag_ovf  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= exec_go;
      if (flag_evt) begin
        flag_sign <= alu.sf;
        flag_zero <= alu.zf;
        flag_ovf  <= alu.of;
      end
    end
  end

  assign done = done_q;
  assign err  = halted;

  // R12: completion pulse never spans two cycles
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1: no byte is offered acceptance while halted
  p_err_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);

  // R9: flags move only on an arithmetic or logic execution
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_evt |=> $stable({flag_sign, flag_zero, flag_ovf}));

  // R10: compare never produces a write strobe
  p_cmp_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && !req.push && (req.op == ALU_CMP)) |-> !(reg_we || mem_we));

endmodule

// File: tb/imm_exec_core_tb_top.sv
module imm_exec_core_tb_top;

  localparam int MW  = 32;
  localparam int MAW = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, done, err, flag_sign, flag_zero, flag_ovf;
  logic [2:0]  dbg_reg_sel = 3'd0;
  logic [31:0] dbg_reg_val;
  logic [MAW-1:0] dbg_mem_sel = '0;
  logic [31:0] dbg_mem_val;

  always #10 clk = ~clk;  // 50 MHz

  imm_exec_core #(.MEM_WORDS(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .err(err),
    .flag_sign(flag_sign), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val)
  );

  typedef struct {
    bit          cr;
    int          ri;
    logic [31:0] rv;
    bit          cm;
    int          mi;
    logic [31:0] mv;
    logic [2:0]  fl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] m_reg [8];
  logic [31:0] m_mem [MW];
  bit m_sf, m_zf, m_of;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int widx(logic [31:0] a);
    return int'((a >> 2) % MW);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    for (int i = 0; i < MW; i++) m_mem[i] = '0;
    m_sf = 0; m_zf = 0; m_of = 0;
  endtask

  // Reference arithmetic via 64-bit signed sums
  task automatic model_op(int op, logic [31:0] a, logic [31:0] b, output logic [31:0] r);
    longint sa, sb, s;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    case (op)
      0: begin s = sa + sb; r = s[31:0]; m_of = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      5, 7: begin s = sa - sb; r = s[31:0]; m_of = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      1: begin r = a | b; m_of = 0; end
      4: begin r = a & b; m_of = 0; end
      default: begin r = a ^ b; m_of = 0; end
    endcase
    m_sf = r[31];
    m_zf = (r == 0);
  endtask

  task automatic push_exp(bit cr, int ri, logic [31:0] rv, bit cm, int mi, logic [31:0] mv, string tag);
    exp_t e;
    e.cr = cr; e.ri = ri; e.rv = rv; e.cm = cm; e.mi = mi; e.mv = mv;
    e.fl = {m_sf, m_zf, m_of}; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic put_byte(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic send(logic [7:0] opc, bit has_m, logic [7:0] m, logic [31:0] imm);
    put_byte(opc);
    if (has_m) put_byte(m);
    for (int k = 0; k < 4; k++) put_byte(imm[8*k +: 8]);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R1 ready low in execute", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic do_mov(int r, logic [31:0] imm);
    m_reg[r] = imm;
    push_exp(1, r, imm, 0, 0, 0, "R6/R2 move");
    send(8'hb8 + 8'(r), 0, 8'h00, imm);
  endtask

  task automatic do_grp(int sub, int r, bit mem, logic [31:0] imm);
    logic [31:0] a, res;
    int mi;
    mi = widx(m_reg[r]);
    a  = mem ? m_mem[mi] : m_reg[r];
    model_op(sub, a, imm, res);
    if (sub != 7) begin
      if (mem) m_mem[mi] = res; else m_reg[r] = res;
    end
    if (mem) push_exp(0, 0, 0, 1, mi, m_mem[mi], sub == 7 ? "R10/R4 group compare mem" : "R4 group mem");
    else     push_exp(1, r, m_reg[r], 0, 0, 0, sub == 7 ? "R10/R3 group compare reg" : "R3 group reg");
    send(8'h81, 1, {mem ? 2'b00 : 2'b11, 3'(sub), 3'(r)}, imm);
  endtask

  task automatic do_acc(logic [7:0] opc, int sub, logic [31:0] imm);
    logic [31:0] res;
    model_op(sub, m_reg[0], imm, res);
    if (sub != 7) m_reg[0] = res;
    push_exp(1, 0, m_reg[0], 0, 0, 0, sub == 7 ? "R10/R5 acc compare" : "R5 acc");
    send(opc, 0, 8'h00, imm);
  endtask

  task automatic do_store(int r, bit mem, logic [31:0] imm);
    int mi;
    mi = widx(m_reg[r]);
    if (mem) begin
      m_mem[mi] = imm;
      push_exp(0, 0, 0, 1, mi, imm, "R7 store mem");
    end else begin
      m_reg[r] = imm;
      push_exp(1, r, imm, 0, 0, 0, "R7 store reg");
    end
    send(8'hc7, 1, {mem ? 2'b00 : 2'b11, 3'b000, 3'(r)}, imm);
  endtask

  task automatic do_push(logic [31:0] imm);
    logic [31:0] sp;
    sp = m_reg[4] - 32'd4;
    m_reg[4] = sp;
    m_mem[widx(sp)] = imm;
    push_exp(1, 4, sp, 1, widx(sp), imm, "R8 push");
    send(8'h68, 0, 8'h00, imm);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    exp_q.delete();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bad_stream(logic [7:0] b0, bit two, logic [7:0] b1, string what);
    bit ok;
    do_reset();
    put_byte(b0);
    if (two) put_byte(b1);
    ok = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = 8'hb8;
      if (!(err && !in_ready && !done)) ok = 0;
    end
    in_valid = 1'b0;
    chk(ok, {"R11 halt ", what}, {29'd0, err, in_ready, done}, 32'd4);
  endtask

  // Scoreboard monitor: pops one expected item per completion pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R12 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          dbg_reg_sel = 3'(e.ri);
          dbg_mem_sel = MAW'(e.mi);
          #1;
          if (e.cr) chk(dbg_reg_val == e.rv, {e.tag, " reg"}, dbg_reg_val, e.rv);
          if (e.cm) chk(dbg_mem_val == e.mv, {e.tag, " mem"}, dbg_mem_val, e.mv);
          chk({flag_sign, flag_zero, flag_ovf} == e.fl, {"R9 flags after ", e.tag},
              {29'd0, flag_sign, flag_zero, flag_ovf}, {29'd0, e.fl});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    @(negedge clk);
    // R13 reset state
    chk(!err && in_ready && !done, "R13 reset handshake", {29'd0, err, in_ready, done}, 32'd2);
    chk({flag_sign, flag_zero, flag_ovf} == 3'b000, "R13 reset flags",
        {29'd0, flag_sign, flag_zero, flag_ovf}, 32'd0);
    chk(dbg_reg_val == 0 && dbg_mem_val == 0, "R13 reset storage", dbg_reg_val | dbg_mem_val, 32'd0);

    do_mov(3, 32'h0d0c0b0a);
    do_mov(3, 32'h00000001);
    do_grp(0, 3, 0, 32'h0d0c0b0a);
    do_mov(1, 32'h7fffffff);
    do_grp(0, 1, 0, 32'h00000001);
    do_grp(5, 1, 0, 32'h00000001);
    do_mov(0, 32'h0d0c0b0a);
    do_acc(8'h3d, 7, 32'h0d0c0b07);
    do_acc(8'h3d, 7, 32'h0d0c0b0a);
    do_mov(0, 32'h0d0c0b07);
    do_acc(8'h3d, 7, 32'h0d0c0b0a);
    do_mov(0, 32'h000000ff);
    do_acc(8'h25, 4, 32'h0d0c0b0a);
    do_mov(0, 32'hd0c0b0a0);
    do_acc(8'h0d, 1, 32'h0d0c0b0a);
    do_acc(8'h35, 6, 32'h0d0c0b0a);
    do_acc(8'h2d, 5, 32'h0d0c0baa);
    do_mov(2, 32'hd0c0b0a0);
    do_grp(1, 2, 0, 32'h0d0c0b0a);
    do_grp(6, 2, 0, 32'hddccbbaa);
    do_grp(4, 2, 0, 32'h12345678);
    do_grp(7, 2, 0, 32'h00000000);
    do_mov(3, 32'h00000060);
    do_store(3, 1, 32'h00000001);
    do_grp(0, 3, 1, 32'h0d0c0b0a);
    do_grp(5, 3, 1, 32'h00000001);
    do_grp(7, 3, 1, 32'h0d0c0b0a);
    do_grp(6, 3, 1, 32'hffffffff);
    do_store(5, 0, 32'hcafe0001);
    do_mov(4, 32'h00000014);
    do_push(32'h000000af);
    do_push(32'h12345678);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R12 every instruction completed", exp_q.size(), 32'd0);

    bad_stream(8'h05, 0, 8'h00, "unknown opcode");
    bad_stream(8'h81, 1, 8'hd3, "group op 2");
    bad_stream(8'h81, 1, 8'hdb, "group op 3");
    bad_stream(8'h81, 1, 8'h43, "mod 1");
    bad_stream(8'h81, 1, 8'h83, "mod 2");
    bad_stream(8'h81, 1, 8'h04, "base 4");
    bad_stream(8'hc7, 1, 8'h05, "base 5");
    bad_stream(8'hc7, 1, 8'hcb, "store reg field");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule